// File: doc/BRIEF.md
# Flash Write-Buffer Command Interpreter

This block is the device-side command decoder of a NOR-style flash array. It watches bus write cycles and runs the buffered program sequence. A setup write (code 0xE8) names a target block. A count write gives n, where n+1 is the number of words to load. Then n+1 address/data load writes follow, and a confirm write (0xD0) ends the sequence. Each write is checked against the rules of the sequence. If any check fails, an error bit is set and the sequence is dropped with the array left as it was. When the sequence is valid, the collected words go to an internal program engine through a start/busy/done handshake.

The array is a behavioural register memory split into equal blocks, and each block has a lock input. Programming follows flash semantics: a cell can only move from 1 to 0, so a programmed word becomes old AND new. Reads use one read port that returns the array, the status byte, an identifier or a query word, depending on the last read-mode command. Those commands are 0xFF, 0x70, 0x90 and 0x98. While the engine is busy, only the read-mode commands and suspend (0xB0) are taken; resume (0xD0) is also taken while suspended. Every command uses the low data byte.

Top module: `flash_wbuf_ctrl`

## Requirements
- R1: After reset, `busy` is 0, every array word reads 0xFFFF, and after a 0x70 command the read port returns status 0x0080.
- R2: A valid sequence programs each loaded word at its own address to old AND data, leaves the other words unchanged, and then returns status 0x0080.
- R3: After the setup write, the read port returns the status byte, and bit 7 (buffer ready) is 1 when the engine is idle.
- R4: A count value above 31 sets status bit 4 (sequence error), ends the sequence and leaves the array unchanged.
- R5: A load address in a block other than the setup block sets bit 4 and aborts with the array unchanged. So does an address below the first loaded address, or more than n above it.
- R6: After the last load, a write whose low byte is not 0xD0 sets bit 4 and programs nothing. So does a confirm addressed outside the target block.
- R7: Confirming into a block whose `blk_lock` bit is 1 sets status bit 1 (lock error), keeps `busy` low and leaves the array unchanged.
- R8: `busy` stays high for exactly 1 + (n+1)×PROG_CYC cycles. During that time, status bit 7 reads 0, and setup and clear-status writes have no effect.
- R9: A 0xB0 write while busy freezes programming: status reads 0x00C0, no word changes and `busy` stays high. A later 0xD0 write lets the operation finish.
- R10: A 0x50 write while idle clears status bits 4 and 1.
- R11: After 0x90, even addresses read 0x00A5 and odd addresses read 0x5A17. After 0x98, offsets 0x10, 0x11 and 0x12 read 0x0051, 0x0052 and 0x0059, and other offsets read 0.
- R12: A count write addressed to a block other than the setup block sets bit 4 and ends the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per bus write |
| bus_addr | input | AW | Word address of the write |
| bus_data | input | 16 | Write data; commands in the low byte |
| rd_addr | input | AW | Read address |
| rd_data | output | 16 | Registered read data, one cycle after `rd_addr` |
| blk_lock | input | NBLK | Lock bit per block |
| busy | output | 1 | Program operation in progress |

## Verification
Four rules are checked by assertions on every cycle. The engine only writes while busy. Every write lands inside the target block and inside the loaded window. A start only follows a confirm write and never reaches a locked block. No write happens while suspended. The bench scenarios are the only evidence for the values that come out of the read port: the AND result of programming, the status byte after each kind of abort, the exact busy length, and whether commands given while busy are really dropped.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    localparam int WORD_W = 16;

    localparam logic [7:0] CMD_SETUP   = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_RD_ARR  = 8'hFF;
    localparam logic [7:0] CMD_RD_STAT = 8'h70;
    localparam logic [7:0] CMD_RD_ID   = 8'h90;
    localparam logic [7:0] CMD_RD_QRY  = 8'h98;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;

    localparam logic [WORD_W-1:0] ID_MAKER  = 16'h00A5;
    localparam logic [WORD_W-1:0] ID_DEVICE = 16'h5A17;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_IDENT,
        RM_QUERY
    } rmode_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_COUNT,
        SQ_LOAD,
        SQ_CONFIRM
    } sq_state_t;

    typedef struct packed {
        logic ready;
        logic susp;
        logic err_seq;
        logic err_lock;
    } stat_t;

    function automatic logic [7:0] stat_byte(stat_t s);
        return {s.ready, s.susp, 1'b0, s.err_seq, 2'b00, s.err_lock, 1'b0};
    endfunction

    function automatic logic is_read_cmd(logic [7:0] c);
        return (c == CMD_RD_ARR) || (c == CMD_RD_STAT) ||
               (c == CMD_RD_ID)  || (c == CMD_RD_QRY);
    endfunction

    function automatic rmode_t read_mode_of(logic [7:0] c);
        case (c)
            CMD_RD_STAT: return RM_STATUS;
            CMD_RD_ID:   return RM_IDENT;
            CMD_RD_QRY:  return RM_QUERY;
            default:     return RM_ARRAY;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] query_word(logic [7:0] ofs);
        case (ofs)
            8'h10:   return 16'h0051;
            8'h11:   return 16'h0052;
            8'h12:   return 16'h0059;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/wbc_seq.sv
module wbc_seq
    import wbc_pkg::*;
#(
    parameter int AW        = 8,
    parameter int BLK_AW    = 6,
    parameter int NBLK      = 4,
    parameter int BUF_WORDS = 32,
    localparam int BUF_AW   = $clog2(BUF_WORDS),
    localparam int BLK_W    = AW - BLK_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] data,
    input  logic [NBLK-1:0]   blk_lock,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [BUF_AW-1:0] eng_idx,
    output logic [WORD_W-1:0] buf_word,
    output logic              buf_hit,
    output logic              prog_start,
    output logic [AW-1:0]     prog_base,
    output logic [BUF_AW-1:0] prog_last,
    output logic              susp,
    output rmode_t            rmode,
    output logic [7:0]        sr
);

    sq_state_t             st;
    logic [BLK_W-1:0]      tgt_blk;
    logic [BUF_AW-1:0]     n_q;
    logic [BUF_AW-1:0]     cnt_q;
    logic [AW-1:0]         base_q;
    logic [WORD_W-1:0]     bdat [BUF_WORDS];
    logic [BUF_WORDS-1:0]  bvld;
    logic                  err_seq, err_lock, susp_q;
    rmode_t                rm_q;

    logic                  busy_any;
    logic [7:0]            cmd;
    logic [BLK_W-1:0]      wblk;
    logic                  blk_ok;
    logic [AW-1:0]         ofs;
    logic                  in_win;
    logic [BUF_AW-1:0]     slot;
    logic                  load_ok;
    stat_t                 st_fields;

    always_comb begin
        busy_any = prog_start | eng_busy;
        cmd      = data[7:0];
        wblk     = addr[AW-1:BLK_AW];
        blk_ok   = (wblk == tgt_blk);
        ofs      = addr - base_q;
        in_win   = (cnt_q == '0) || ((addr >= base_q) && (ofs <= AW'(n_q)));
        slot     = (cnt_q == '0) ? '0 : ofs[BUF_AW-1:0];
        load_ok  = we && (st == SQ_LOAD) && blk_ok && in_win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            tgt_blk    <= '0;
            n_q        <= '0;
            cnt_q      <= '0;
            base_q     <= '0;
            bvld       <= '0;
            err_seq    <= 1'b0;
            err_lock   <= 1'b0;
            susp_q     <= 1'b0;
            rm_q       <= RM_ARRAY;
            prog_start <= 1'b0;
        end else begin
            prog_start <= 1'b0;
            if (eng_done) susp_q <= 1'b0;
            if (we) begin
                case (st)
                    SQ_IDLE: begin
                        if (busy_any) begin
                            if (is_read_cmd(cmd))
                                rm_q <= read_mode_of(cmd);
                            else if (cmd == CMD_SUSPEND && eng_busy)
                                susp_q <= 1'b1;
                            else if (cmd == CMD_CONFIRM && susp_q)
                                susp_q <= 1'b0;
                        end else begin
                            if (is_read_cmd(cmd)) begin
                                rm_q <= read_mode_of(cmd);
                            end else if (cmd == CMD_CLEAR) begin
                                err_seq  <= 1'b0;
                                err_lock <= 1'b0;
                            end else if (cmd == CMD_SETUP) begin
                                st      <= SQ_COUNT;
                                tgt_blk <= wblk;
                                rm_q    <= RM_STATUS;
                                bvld    <= '0;
                            end
                        end
                    end
                    SQ_COUNT: begin
                        if (!blk_ok || data > WORD_W'(BUF_WORDS - 1)) begin
                            err_seq <= 1'b1;
                            st      <= SQ_IDLE;
                        end else begin
                            n_q   <= data[BUF_AW-1:0];
                            cnt_q <= '0;
                            st    <= SQ_LOAD;
                        end
                    end
                    SQ_LOAD: begin
                        if (!load_ok) begin
                            err_seq <= 1'b1;
                            st      <= SQ_IDLE;
                        end else begin
                            if (cnt_q == '0) base_q <= addr;
                            bvld[slot] <= 1'b1;
                            cnt_q      <= cnt_q + 1'b1;
                            if (cnt_q == n_q) st <= SQ_CONFIRM;
                        end
                    end
                    SQ_CONFIRM: begin
                        st <= SQ_IDLE;
                        if (!blk_ok || cmd != CMD_CONFIRM)
                            err_seq <= 1'b1;
                        else if (blk_lock[tgt_blk])
                            err_lock <= 1'b1;
                        else
                            prog_start <= 1'b1;
                    end
                    default: st <= SQ_IDLE;
                endcase
            end
        end
    end

    // Buffer data needs no reset: the valid bits gate every use.
    always_ff @(posedge clk) begin
        if (load_ok) bdat[slot] <= data;
    end

    always_comb begin
        st_fields.ready    = ~busy_any | susp_q;
        st_fields.susp     = susp_q;
        st_fields.err_seq  = err_seq;
        st_fields.err_lock = err_lock;
        sr        = stat_byte(st_fields);
        buf_word  = bdat[eng_idx];
        buf_hit   = bvld[eng_idx];
        prog_base = base_q;
        prog_last = n_q;
        susp      = susp_q;
        rmode     = rm_q;
    end

endmodule

// File: rtl/wbc_engine.sv
module wbc_engine
    import wbc_pkg::*;
#(
    parameter int AW       = 8,
    parameter int BUF_AW   = 5,
    parameter int PROG_CYC = 4,
    localparam int TW      = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     base,
    input  logic [BUF_AW-1:0] last,
    input  logic              susp,
    input  logic [WORD_W-1:0] buf_word,
    input  logic              buf_hit,
    output logic [BUF_AW-1:0] idx,
    output logic              busy,
    output logic              done,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [WORD_W-1:0] mem_wdata
);

    logic [TW-1:0]     tick;
    logic [AW-1:0]     base_l;
    logic [BUF_AW-1:0] last_l;
    logic              step;

    always_comb begin
        step      = busy && !susp && (tick == TW'(PROG_CYC - 1));
        mem_we    = step && buf_hit;
        mem_waddr = base_l + AW'(idx);
        mem_wdata = buf_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            idx    <= '0;
            tick   <= '0;
            base_l <= '0;
            last_l <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy   <= 1'b1;
                idx    <= '0;
                tick   <= '0;
                base_l <= base;
                last_l <= last;
            end else if (busy && !susp) begin
                if (step) begin
                    tick <= '0;
                    if (idx == last_l) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end else begin
                    tick <= tick + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wbc_array.sv
module wbc_array
    import wbc_pkg::*;
#(
    parameter int AW     = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    input  rmode_t            rmode,
    input  logic [7:0]        sr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Erased cells read as ones; programming can only clear bits.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            case (rmode)
                RM_STATUS: rdata <= {8'h00, sr};
                RM_IDENT:  rdata <= raddr[0] ? ID_DEVICE : ID_MAKER;
                RM_QUERY:  rdata <= query_word(8'(raddr));
                default:   rdata <= mem[raddr];
            endcase
        end
    end

endmodule

// File: rtl/flash_wbuf_ctrl.sv
module flash_wbuf_ctrl
    import wbc_pkg::*;
#(
    parameter int BLK_AW    = 6,
    parameter int NBLK      = 4,
    parameter int BUF_WORDS = 32,
    parameter int PROG_CYC  = 4,
    localparam int AW       = BLK_AW + $clog2(NBLK),
    localparam int BUF_AW   = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [WORD_W-1:0] bus_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic [NBLK-1:0]   blk_lock,
    output logic              busy
);

    logic              eng_busy, eng_done, prog_start, susp;
    logic [BUF_AW-1:0] eng_idx, prog_last;
    logic [WORD_W-1:0] buf_word, mem_wdata;
    logic              buf_hit, mem_we;
    logic [AW-1:0]     prog_base, mem_waddr;
    logic [7:0]        sr;
    rmode_t            rmode;

    wbc_seq #(
        .AW(AW), .BLK_AW(BLK_AW), .NBLK(NBLK), .BUF_WORDS(BUF_WORDS)
    ) u_seq (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .data(bus_data),
        .blk_lock(blk_lock), .eng_busy(eng_busy), .eng_done(eng_done),
        .eng_idx(eng_idx), .buf_word(buf_word), .buf_hit(buf_hit),
        .prog_start(prog_start), .prog_base(prog_base), .prog_last(prog_last),
        .susp(susp), .rmode(rmode), .sr(sr)
    );

    wbc_engine #(
        .AW(AW), .BUF_AW(BUF_AW), .PROG_CYC(PROG_CYC)
    ) u_eng (
        .clk(clk), .rst(rst), .start(prog_start), .base(prog_base),
        .last(prog_last), .susp(susp), .buf_word(buf_word), .buf_hit(buf_hit),
        .idx(eng_idx), .busy(eng_busy), .done(eng_done), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    wbc_array #(
        .AW(AW)
    ) u_arr (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(rd_addr), .rmode(rmode), .sr(sr), .rdata(rd_data)
    );

    assign busy = prog_start | eng_busy;

endmodule

// File: rtl/wbc_chk.sv
module wbc_chk #(
    parameter int AW     = 8,
    parameter int BLK_AW = 6,
    parameter int NBLK   = 4,
    parameter int BUF_AW = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [15:0]       bus_data,
    input logic [NBLK-1:0]   blk_lock,
    input logic              prog_start,
    input logic [AW-1:0]     prog_base,
    input logic [BUF_AW-1:0] prog_last,
    input logic              eng_busy,
    input logic              eng_done,
    input logic              susp,
    input logic              mem_we,
    input logic [AW-1:0]     mem_waddr
);

    assert_write_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> eng_busy);

    assert_write_in_window_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_waddr[AW-1:BLK_AW] == prog_base[AW-1:BLK_AW]) &&
                   (mem_waddr >= prog_base) &&
                   ((mem_waddr - prog_base) <= AW'(prog_last)));

    assert_start_after_confirm_R6: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> $past(bus_we) && ($past(bus_data[7:0]) == 8'hD0));

    assert_no_start_locked_R7: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> !blk_lock[prog_base[AW-1:BLK_AW]]);

    assert_no_restart_busy_R8: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> !prog_start);

    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
        eng_done |-> !eng_busy && $past(eng_busy));

    assert_frozen_suspend_R9: assert property (@(posedge clk) disable iff (rst)
        susp |-> !mem_we);

endmodule

bind flash_wbuf_ctrl wbc_chk #(
    .AW(AW), .BLK_AW(BLK_AW), .NBLK(NBLK), .BUF_AW(BUF_AW)
) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_data(bus_data),
    .blk_lock(blk_lock), .prog_start(prog_start), .prog_base(prog_base),
    .prog_last(prog_last), .eng_busy(eng_busy), .eng_done(eng_done),
    .susp(susp), .mem_we(mem_we), .mem_waddr(mem_waddr)
);

// File: tb/sim_flash_wbuf_ctrl.sv
module sim_flash_wbuf_ctrl;

    localparam int AW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [15:0]     bus_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [15:0]     rd_data;
    logic [3:0]      blk_lock = 4'b1000;
    logic            busy;

    always #10 clk = ~clk;

    flash_wbuf_ctrl u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_data(bus_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .blk_lock(blk_lock), .busy(busy)
    );

    typedef struct {
        int          due;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    total = 0;
    int    failed = 0;

    function automatic void judge(logic [15:0] act, logic [15:0] exp, string req);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares each expected read when its cycle comes up.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due == cyc) begin
            item_t it;
            it = sbq.pop_front();
            judge(rd_data, it.exp, it.req);
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_data = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        rd_addr = a;
        sbq.push_back('{cyc + 1, exp, req});
        @(negedge clk);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy === 1'b1 && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - failed, total);
    endtask

    initial begin
        #(20 * 100000);
        total++; failed++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        judge(16'(busy), 16'h0, "R1 busy after reset");
        rd_chk(8'h00, 16'hFFFF, "R1 erased array");
        rd_chk(8'hFF, 16'hFFFF, "R1 erased array top");
        wr(8'h00, 16'h0070);
        rd_chk(8'h00, 16'h0080, "R1 status after reset");

        // R11: identifier and query reads
        wr(8'h00, 16'h0090);
        rd_chk(8'h00, 16'h00A5, "R11 maker id");
        rd_chk(8'h01, 16'h5A17, "R11 device id");
        wr(8'h00, 16'h0098);
        rd_chk(8'h10, 16'h0051, "R11 query 0x10");
        rd_chk(8'h11, 16'h0052, "R11 query 0x11");
        rd_chk(8'h12, 16'h0059, "R11 query 0x12");
        rd_chk(8'h13, 16'h0000, "R11 query other");

        // R3, R2: four-word program, loaded out of order
        wr(8'h45, 16'h00E8);
        rd_chk(8'h00, 16'h0080, "R3 status after setup");
        wr(8'h40, 16'h0003);
        wr(8'h48, 16'h1234);
        wr(8'h4A, 16'hF0F0);
        wr(8'h49, 16'h0FF0);
        wr(8'h4B, 16'hABCD);
        wr(8'h40, 16'h00D0);
        wait_idle(n);
        judge(16'(n), 16'd17, "R8 busy length n=3");
        rd_chk(8'h00, 16'h0080, "R2 status after program");
        wr(8'h00, 16'h00FF);
        rd_chk(8'h48, 16'h1234, "R2 word 0");
        rd_chk(8'h49, 16'h0FF0, "R2 word 1");
        rd_chk(8'h4A, 16'hF0F0, "R2 word 2");
        rd_chk(8'h4B, 16'hABCD, "R2 word 3");
        rd_chk(8'h47, 16'hFFFF, "R2 below window untouched");
        rd_chk(8'h4C, 16'hFFFF, "R2 above window untouched");

        // R2: reprogramming only clears bits
        wr(8'h48, 16'h00E8);
        wr(8'h48, 16'h0000);
        wr(8'h48, 16'h00FF);
        wr(8'h48, 16'h00D0);
        wait_idle(n);
        judge(16'(n), 16'd5, "R8 busy length n=0");
        wr(8'h00, 16'h00FF);
        rd_chk(8'h48, 16'h0034, "R2 old AND new");

        // R4: count above limit
        wr(8'hC0, 16'h00E8);
        wr(8'hC0, 16'h0020);
        rd_chk(8'h00, 16'h0090, "R4 count 32 error");
        wr(8'h00, 16'h00FF);
        rd_chk(8'hC0, 16'hFFFF, "R4 array unchanged");

        // R8: clear and setup ignored while busy
        wr(8'h10, 16'h00E8);
        wr(8'h10, 16'h0001);
        wr(8'h10, 16'h1111);
        wr(8'h11, 16'h2222);
        wr(8'h10, 16'h00D0);
        wr(8'h00, 16'h0050);
        wr(8'hC0, 16'h00E8);
        rd_chk(8'h00, 16'h0010, "R8 status while busy");
        judge(16'(busy), 16'h1, "R8 still busy");
        wait_idle(n);
        rd_chk(8'h00, 16'h0090, "R8 clear while busy ignored");
        wr(8'h00, 16'h00FF);
        rd_chk(8'h10, 16'h1111, "R8 word 0 programmed");
        rd_chk(8'h11, 16'h2222, "R8 word 1 programmed");

        // R10: clear status when idle
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0070);
        rd_chk(8'h00, 16'h0080, "R10 errors cleared");

        // R5: load below start, beyond window, other block
        wr(8'h80, 16'h00E8);
        wr(8'h80, 16'h0002);
        wr(8'h84, 16'h0001);
        wr(8'h83, 16'h0002);
        rd_chk(8'h00, 16'h0090, "R5 below start");
        wr(8'h00, 16'h0050);
        wr(8'h80, 16'h00E8);
        wr(8'h80, 16'h0001);
        wr(8'h84, 16'h0003);
        wr(8'h86, 16'h0004);
        rd_chk(8'h00, 16'h0090, "R5 beyond window");
        wr(8'h00, 16'h0050);
        wr(8'h80, 16'h00E8);
        wr(8'h80, 16'h0001);
        wr(8'h81, 16'h0005);
        wr(8'hC1, 16'h0006);
        rd_chk(8'h00, 16'h0090, "R5 other block");
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h00FF);
        rd_chk(8'h84, 16'hFFFF, "R5 array unchanged a");
        rd_chk(8'h81, 16'hFFFF, "R5 array unchanged b");
        rd_chk(8'hC1, 16'hFFFF, "R5 array unchanged c");

        // R12: count to other block
        wr(8'h80, 16'h00E8);
        wr(8'h40, 16'h0000);
        rd_chk(8'h00, 16'h0090, "R12 count block mismatch");
        wr(8'h00, 16'h0050);

        // R6: wrong confirm code, confirm to other block
        wr(8'h80, 16'h00E8);
        wr(8'h80, 16'h0000);
        wr(8'h85, 16'h0000);
        wr(8'h80, 16'h00FF);
        rd_chk(8'h00, 16'h0090, "R6 wrong confirm code");
        judge(16'(busy), 16'h0, "R6 no start on bad code");
        wr(8'h00, 16'h0050);
        wr(8'h80, 16'h00E8);
        wr(8'h80, 16'h0000);
        wr(8'h85, 16'h0000);
        wr(8'h40, 16'h00D0);
        rd_chk(8'h00, 16'h0090, "R6 confirm other block");
        judge(16'(busy), 16'h0, "R6 no start other block");
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h00FF);
        rd_chk(8'h85, 16'hFFFF, "R6 array unchanged");

        // R7: locked block
        wr(8'hC0, 16'h00E8);
        wr(8'hC0, 16'h0000);
        wr(8'hC1, 16'h0000);
        wr(8'hC0, 16'h00D0);
        rd_chk(8'h00, 16'h0082, "R7 lock error");
        judge(16'(busy), 16'h0, "R7 no start");
        wr(8'h00, 16'h00FF);
        rd_chk(8'hC1, 16'hFFFF, "R7 array unchanged");
        wr(8'h00, 16'h0050);

        // R9: suspend and resume
        wr(8'h20, 16'h00E8);
        wr(8'h20, 16'h0003);
        for (int i = 0; i < 4; i++) wr(8'(8'h20 + i), 16'h0000);
        wr(8'h20, 16'h00D0);
        repeat (6) @(negedge clk);
        wr(8'h00, 16'h00B0);
        rd_chk(8'h00, 16'h00C0, "R9 suspended status");
        wr(8'h00, 16'h00FF);
        rd_chk(8'h23, 16'hFFFF, "R9 last word pending");
        repeat (30) @(negedge clk);
        judge(16'(busy), 16'h1, "R9 busy held in suspend");
        rd_chk(8'h23, 16'hFFFF, "R9 frozen while suspended");
        wr(8'h00, 16'h00D0);
        wait_idle(n);
        for (int i = 0; i < 4; i++) rd_chk(8'(8'h20 + i), 16'h0000, "R9 finished after resume");
        wr(8'h00, 16'h0070);
        rd_chk(8'h00, 16'h0080, "R9 status after resume");

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule